// File: doc/BRIEF.md
# Frequency Error Measurement Counter

This block measures how far a free-running oscillator is from its target frequency. It runs in the clock domain of the oscillator being calibrated and takes a stream of single-cycle synchronization pulses from a trusted reference. On each pulse it reloads a counter with a programmed count and counts down. When the count is exhausted it signals that a pulse is now due, and it keeps counting upward past zero. The next pulse latches how far the counter got and in which direction it was moving. That magnitude and direction bit together give the frequency error, whether the oscillator is slow or fast.

The up-count has a ceiling of the error limit multiplied by 128. If no pulse arrives before the ceiling is reached, the counter halts and reports a missed pulse. A pulse that arrives while the counter is still counting down, with a latched value at or above that same ceiling, is reported as an error that is too large to correct by trimming. Surrounding logic uses the captured value, the direction bit and the three event pulses to decide how to trim the oscillator.

Top module: `freq_err_meter`

## Requirements
- R1: While reset is asserted, and after it is released, every output is zero: capture value, direction, capture strobe, due pulse, missed pulse and error pulse.
- R2: While `en_i` is low the counter idles at zero and no event output or capture strobe is raised, even when `sync_i` pulses. The last captured value and direction stay on the outputs.
- R3: `reload_i` and `lim_i` are copied only while `en_i` is low. Changes made while `en_i` is high have no effect until `en_i` next goes low.
- R4: The first `sync_i` pulse after `en_i` rises only loads the counter. It raises no capture strobe and no event.
- R5: Let R be the held reload value, and let a `sync_i` pulse arrive at the k-th rising edge after the load, with 1 <= k <= R. That pulse captures R-k+1 with direction 0.
- R6: If no pulse arrives first, `esync_o` is high for exactly the one cycle after rising edge R+1 counted from the load.
- R7: Let M = `lim_i`*128. A pulse at edge k >= R+2 captures min(k-R-2, M) with direction 1.
- R8: If no pulse arrives first, `miss_o` is high for the one cycle after edge R+2+M. The counter then halts at M until the next pulse, which captures M with direction 1 and reloads the counter.
- R9: `sync_err_o` pulses together with the capture strobe exactly when the captured direction is 0 and the captured value is at least M.
- R10: A pulse at edge R+1, where the count is zero, is a reload. It captures 0 with direction 0 and suppresses the due pulse.
- R11: `cap_stb_o` is high for one cycle after each capture. Capture, due and missed pulses are mutually exclusive, and the capture outputs change only with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the oscillator under calibration |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Counter enable; low holds the counter idle |
| sync_i | input | 1 | Single-cycle synchronization pulse |
| reload_i | input | 16 | Count loaded at each pulse |
| lim_i | input | 8 | Error limit; the up-count ceiling is this times 128 |
| err_cap_o | output | 16 | Counter value latched at the last pulse |
| err_dir_o | output | 1 | Latched direction: 0 counting down, 1 counting up |
| cap_stb_o | output | 1 | One-cycle strobe when a capture occurs |
| esync_o | output | 1 | One-cycle pulse when the down-count reaches zero |
| miss_o | output | 1 | One-cycle pulse when the up-count hits its ceiling |
| sync_err_o | output | 1 | One-cycle pulse for a down-count capture at or above the ceiling |

## Verification
The assertions take the ceiling from the held copy of the limit, not from the live input. They allow a pulse on any cycle and expect every outcome to come from the synchronized reset and the enable. The stimulus changes inputs only half a cycle away from the active edge and holds each pulse for one cycle. It moves the configuration only while the block is enabled, so the hold copy is tested without giving the checker a moving ceiling.

// File: rtl/fem_pkg.sv
package fem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DOWN = 2'd1,
    PH_UP   = 2'd2,
    PH_HALT = 2'd3
  } fem_phase_e;
endpackage

// File: rtl/fem_cfg_hold.sv
module fem_cfg_hold #(
  parameter int CW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] reload_in,
  input  logic [LW-1:0] lim_in,
  output logic [CW-1:0] reload_q,
  output logic [LW-1:0] lim_q
);
  logic          take_cfg;
  logic [CW-1:0] reload_d;
  logic [LW-1:0] lim_d;

  // copies track the inputs only while the counter is off
  assign take_cfg = ~en;

  always_comb begin
    reload_d = reload_q;
    lim_d    = lim_q;
    if (take_cfg) begin
      reload_d = reload_in;
      lim_d    = lim_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      lim_q    <= '0;
    end else begin
      reload_q <= reload_d;
      lim_q    <= lim_d;
    end
  end
endmodule

// File: rtl/fem_count_core.sv
module fem_count_core
  import fem_pkg::*;
#(
  parameter int CW = 16,
  parameter int LW = 8,
  parameter int MS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync,
  input  logic [CW-1:0] reload,
  input  logic [LW-1:0] lim,
  output logic          take,
  output logic [CW-1:0] take_val,
  output logic          take_dir,
  output logic          zero_hit,
  output logic          ceil_hit,
  output logic          big_err
);
  fem_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ceil_val;

  assign ceil_val = CW'({lim, {MS{1'b0}}});
  assign take_val = cnt_q;
  assign take_dir = (ph_q != PH_DOWN);

  always_comb begin
    cnt_d    = cnt_q;
    ph_d     = ph_q;
    take     = 1'b0;
    zero_hit = 1'b0;
    ceil_hit = 1'b0;
    big_err  = 1'b0;
    if (!en) begin
      cnt_d = '0;
      ph_d  = PH_IDLE;
    end else if (sync) begin
      // reload wins over any count step in the same cycle
      cnt_d   = reload;
      ph_d    = PH_DOWN;
      take    = (ph_q != PH_IDLE);
      big_err = (ph_q == PH_DOWN) && (cnt_q >= ceil_val);
    end else begin
      case (ph_q)
        PH_DOWN: begin
          if (cnt_q == '0) begin
            ph_d     = PH_UP;
            zero_hit = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_UP: begin
          if (cnt_q >= ceil_val) begin
            ph_d     = PH_HALT;
            ceil_hit = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_IDLE;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/fem_event_reg.sv
module fem_event_reg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] take_val,
  input  logic          take_dir,
  input  logic          zero_hit,
  input  logic          ceil_hit,
  input  logic          big_err,
  output logic [CW-1:0] cap_q,
  output logic          dir_q,
  output logic          stb_q,
  output logic          due_q,
  output logic          miss_q,
  output logic          err_q
);
  logic [CW-1:0] cap_d;
  logic          dir_d;

  always_comb begin
    cap_d = cap_q;
    dir_d = dir_q;
    if (take) begin
      cap_d = take_val;
      dir_d = take_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      dir_q  <= 1'b0;
      stb_q  <= 1'b0;
      due_q  <= 1'b0;
      miss_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      dir_q  <= dir_d;
      stb_q  <= take;
      due_q  <= zero_hit;
      miss_q <= ceil_hit;
      err_q  <= big_err;
    end
  end
endmodule

// File: rtl/freq_err_meter.sv
module freq_err_meter #(
  parameter int CW = 16,
  parameter int LW = 8,
  parameter int MS = 7
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          en_i,
  input  logic          sync_i,
  input  logic [CW-1:0] reload_i,
  input  logic [LW-1:0] lim_i,
  output logic [CW-1:0] err_cap_o,
  output logic          err_dir_o,
  output logic          cap_stb_o,
  output logic          esync_o,
  output logic          miss_o,
  output logic          sync_err_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_sync;
  logic [CW-1:0] reload_h;
  logic [LW-1:0] lim_h;
  logic          take, take_dir, zero_hit, ceil_hit, big_err;
  logic [CW-1:0] take_val;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  fem_cfg_hold #(.CW(CW), .LW(LW)) u_hold (
    .clk(clk_i), .rst_n(rst_n_sync), .en(en_i),
    .reload_in(reload_i), .lim_in(lim_i),
    .reload_q(reload_h), .lim_q(lim_h)
  );

  fem_count_core #(.CW(CW), .LW(LW), .MS(MS)) u_core (
    .clk(clk_i), .rst_n(rst_n_sync), .en(en_i), .sync(sync_i),
    .reload(reload_h), .lim(lim_h),
    .take(take), .take_val(take_val), .take_dir(take_dir),
    .zero_hit(zero_hit), .ceil_hit(ceil_hit), .big_err(big_err)
  );

  fem_event_reg #(.CW(CW)) u_evt (
    .clk(clk_i), .rst_n(rst_n_sync),
    .take(take), .take_val(take_val), .take_dir(take_dir),
    .zero_hit(zero_hit), .ceil_hit(ceil_hit), .big_err(big_err),
    .cap_q(err_cap_o), .dir_q(err_dir_o), .stb_q(cap_stb_o),
    .due_q(esync_o), .miss_q(miss_o), .err_q(sync_err_o)
  );
endmodule

// File: rtl/freq_err_meter_chk.sv
module freq_err_meter_chk #(
  parameter int CW = 16,
  parameter int LW = 8,
  parameter int MS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [LW-1:0] lim_h,
  input logic [CW-1:0] cap,
  input logic          dir,
  input logic          stb,
  input logic          due,
  input logic          miss,
  input logic          err
);
  logic          seen_q;
  logic [CW-1:0] ceil_v;

  assign ceil_v = CW'({lim_h, {MS{1'b0}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(stb || due || miss || err)); // R2
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb, due, miss})); // R11
  AST_ERR_ON_DOWN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (stb && !dir && (cap >= ceil_v))); // R9
  AST_UP_CAPTURE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && dir) |-> (cap <= ceil_v)); // R7
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !stb) |-> ($stable(cap) && $stable(dir))); // R11
endmodule

bind freq_err_meter freq_err_meter_chk #(.CW(CW), .LW(LW), .MS(MS)) u_chk (
  .clk(clk_i), .rst_n(rst_n_sync), .en(en_i), .lim_h(lim_h),
  .cap(err_cap_o), .dir(err_dir_o), .stb(cap_stb_o),
  .due(esync_o), .miss(miss_o), .err(sync_err_o)
);

// File: tb/freq_err_meter_bench.sv
`timescale 1ns/1ps
module freq_err_meter_bench;
  logic        clk_i = 1'b0;
  logic        rst_n_i, en_i, sync_i;
  logic [15:0] reload_i;
  logic [7:0]  lim_i;
  logic [15:0] err_cap_o;
  logic        err_dir_o, cap_stb_o, esync_o, miss_o, sync_err_o;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2 clk_i = ~clk_i;

  freq_err_meter u_freq_err_meter (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .en_i(en_i), .sync_i(sync_i),
    .reload_i(reload_i), .lim_i(lim_i),
    .err_cap_o(err_cap_o), .err_dir_o(err_dir_o), .cap_stb_o(cap_stb_o),
    .esync_o(esync_o), .miss_o(miss_o), .sync_err_o(sync_err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit s);
    sync_i = s;
    @(posedge clk_i);
    @(negedge clk_i);
    sync_i = 1'b0;
  endtask

  task automatic all_zero(input string req);
    chk(req, "cap", err_cap_o, 0);
    chk(req, "dir", err_dir_o, 0);
    chk(req, "stb", cap_stb_o, 0);
    chk(req, "esync", esync_o, 0);
    chk(req, "miss", miss_o, 0);
    chk(req, "serr", sync_err_o, 0);
  endtask

  task automatic trial(input int r, input int l, input int j);
    int m, v, d;
    string tag;
    m = l * 128;
    en_i = 1'b0; reload_i = 16'(r); lim_i = 8'(l);
    step(1'b0); step(1'b0);
    en_i = 1'b1;
    reload_i = 16'(~r); lim_i = 8'(~l);  // R3: ignored while enabled
    step(1'b0);
    step(1'b1);
    chk("R4", "stb", cap_stb_o, 0);
    chk("R4", "esync", esync_o, 0);
    for (int k = 1; k <= j; k++) begin
      step(k == j);
      if (k < j) begin
        chk("R6", "esync", esync_o, (k == r + 1) ? 1 : 0);
        chk("R8", "miss", miss_o, (k == r + 2 + m) ? 1 : 0);
        chk("R11", "stb", cap_stb_o, 0);
      end else begin
        if (k <= r + 1) begin
          v = r - k + 1; d = 0;
          tag = (k == r + 1) ? "R10" : "R5";
        end else begin
          v = (k - r - 2 < m) ? k - r - 2 : m; d = 1;
          tag = (k > r + 2 + m) ? "R8" : "R7";
        end
        chk("R11", "stb", cap_stb_o, 1);
        chk(tag, "cap", err_cap_o, v);
        chk(tag, "dir", err_dir_o, d);
        chk("R3", "cap_frozen_cfg", err_cap_o, v);
        chk("R9", "serr", sync_err_o, (d == 0 && v >= m) ? 1 : 0);
        chk("R10", "esync", esync_o, 0);
        chk("R11", "miss", miss_o, 0);
      end
    end
    en_i = 1'b0;
    step(1'b1);
    chk("R2", "stb", cap_stb_o, 0);
    chk("R2", "esync", esync_o, 0);
    chk("R2", "cap_held", err_cap_o, v);
    chk("R2", "dir_held", err_dir_o, d);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int rs[4];
    int ls[4];
    rs = '{0, 3, 3, 130};
    ls = '{0, 0, 1, 1};
    rst_n_i = 1'b0; en_i = 1'b0; sync_i = 1'b0;
    reload_i = 16'd5; lim_i = 8'd1;
    repeat (4) @(negedge clk_i);
    all_zero("R1");
    rst_n_i = 1'b1;
    repeat (4) step(1'b0);
    all_zero("R1");
    for (int c = 0; c < 4; c++) begin
      for (int j = 1; j <= rs[c] + ls[c] * 128 + 4; j++) begin
        trial(rs[c], ls[c], j);
      end
    end
    finish_run();
  end
endmodule